// File: doc/BRIEF.md
# Transfer Count Register Block

This block holds the byte-wide transfer counter of a storage bus controller. Software writes the low, middle and high count bytes into a shadow copy. A command write that carries the DMA flag copies the shadow into the live counter, and the data-movement logic then counts that live value down. Reads always return the live counter. The one exception is the high byte: until software writes it for the first time, reading it returns a fixed identification byte, which lets a driver tell which controller variant it is talking to.

The block supplies the live count, the effective length in which a zero count stands for 65536 bytes, and the transfer length actually granted, which is the smaller of the effective length and the data still outstanding. It also owns the terminal-count (TC) status flag. A decrement port takes steps of one or two bytes. A completion strobe zeroes the counter and raises TC.

Top module: `xfer_count_regs`

## Requirements
- R1: After reset the shadow and live counts are zero, TC is 0, DMA mode is 0, and reading the high byte (rdSel=2) returns CHIP_ID (default 8'hA2).
- R2: A write with wrSel 0, 1 or 2 stores wrData into the shadow low, middle or high byte only. The live count is unchanged until a reload.
- R3: Any write with wrSel 0, 1 or 2 clears TC on the next cycle, unless TC is set in that same cycle.
- R4: A write with wrSel=2 sets a sticky flag. After that flag is set, reading rdSel=2 returns the live high byte and no longer returns CHIP_ID.
- R5: A command write (wrSel=3) with wrData[7]=1 copies all three shadow bytes into the live count and sets dmaMode. A command write with wrData[7]=0 clears dmaMode and leaves the live count unchanged.
- R6: liveCount equals low | middle<<8 | high<<16. rdSel 0 and 1 return the live low and middle bytes.
- R7: effLen equals liveCount, except that a zero count gives 24'h010000.
- R8: xferLen equals the smaller of effLen and pendSize.
- R9: decEn lowers the live count by 1, or by 2 when decTwo=1. A decrement that reaches zero sets TC. A decrement never takes the count below zero, and a decrement at zero changes nothing.
- R10: doneIn zeroes the live count and sets TC.
- R11: When events coincide, doneIn wins over a DMA reload, and a DMA reload wins over a decrement, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 low, 1 middle, 2 high, 3 command |
| wrData | input | 8 | Write data; bit 7 is the DMA flag on a command |
| rdSel | input | 2 | Read byte select: 0 low, 1 middle, 2 high |
| rdData | output | 8 | Read data |
| decEn | input | 1 | Decrement strobe from the data-movement logic |
| decTwo | input | 1 | Decrement step of two instead of one |
| doneIn | input | 1 | Transfer completion strobe |
| pendSize | input | 24 | Outstanding data size |
| liveCount | output | 24 | Live transfer count |
| effLen | output | 24 | Effective length, zero mapped to 65536 |
| xferLen | output | 24 | Granted length, min(effLen, pendSize) |
| tcFlag | output | 1 | Terminal-count status |
| dmaMode | output | 1 | DMA flag of the last command |

## Verification
The hardest situations to reach are coincident events: a DMA reload arriving in the same cycle as a decrement or a completion, and a two-byte step taken when only one byte is left. The directed tasks drive these combinations in a single cycle through the normal write and decrement ports. The counter is first loaded to small values such as 1 or 3, so that saturation and the point where TC is set are visible after one or two steps. The chip-ID read is checked before and after a high-byte write of zero, because that zero value tells the live byte apart from the identification byte.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
  parameter int unsigned XCR_BYTES = 3;
  parameter int unsigned XCR_ZERO_LEN = 65536;

  typedef struct packed {
    logic [XCR_BYTES-1:0] shadowWr;
    logic                 reload;
    logic                 clear;
    logic                 dec;
    logic                 decTwo;
  } xcrStrobes_t;
endpackage

// File: rtl/xcr_ctrl.sv
module xcr_ctrl
  import xcr_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [7:0]       wrData,
  input  logic             decEn,
  input  logic             decTwo,
  input  logic             doneIn,
  input  logic             atOne,
  input  logic             atTwo,
  output xcrStrobes_t      strobes,
  output logic             tcFlag,
  output logic             dmaMode,
  output logic             hiWritten
);
  localparam int unsigned HI_SEL  = XCR_BYTES - 1;
  localparam int unsigned CMD_SEL = XCR_BYTES;

  logic isCmd, cmdDma, countWr, tcSet;

  assign isCmd   = wrEn && (int'(wrSel) == CMD_SEL);
  assign cmdDma  = isCmd && wrData[7];
  assign countWr = wrEn && (int'(wrSel) < XCR_BYTES);

  always_comb begin
    for (int b = 0; b < XCR_BYTES; b++) begin
      strobes.shadowWr[b] = wrEn && (int'(wrSel) == b);
    end
    strobes.clear  = doneIn;
    strobes.reload = cmdDma && !doneIn;
    strobes.dec    = decEn && !doneIn && !cmdDma;
    strobes.decTwo = decTwo;
  end

  assign tcSet = strobes.clear || (strobes.dec && (atOne || (decTwo && atTwo)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tcFlag    <= 1'b0;
      dmaMode   <= 1'b0;
      hiWritten <= 1'b0;
    end else begin
      if (tcSet)        tcFlag <= 1'b1;
      else if (countWr) tcFlag <= 1'b0;
      if (isCmd)        dmaMode <= wrData[7];
      if (wrEn && (int'(wrSel) == HI_SEL)) hiWritten <= 1'b1;
    end
  end
endmodule

// File: rtl/xcr_datapath.sv
module xcr_datapath
  import xcr_pkg::*;
#(
  parameter int unsigned SEL_W   = 2,
  parameter logic [7:0]  CHIP_ID = 8'hA2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  xcrStrobes_t              strobes,
  input  logic [7:0]               wrData,
  input  logic [SEL_W-1:0]         rdSel,
  input  logic                     hiWritten,
  input  logic [8*XCR_BYTES-1:0]   pendSize,
  output logic [7:0]               rdData,
  output logic [8*XCR_BYTES-1:0]   liveCount,
  output logic [8*XCR_BYTES-1:0]   effLen,
  output logic [8*XCR_BYTES-1:0]   xferLen,
  output logic                     atOne,
  output logic                     atTwo
);
  localparam int unsigned COUNT_W = 8 * XCR_BYTES;
  localparam int unsigned HI_SEL  = XCR_BYTES - 1;
  localparam logic [COUNT_W-1:0] ZERO_LEN = COUNT_W'(XCR_ZERO_LEN);

  logic [COUNT_W-1:0] shadowVec;
  logic [COUNT_W-1:0] stepVal;

  for (genvar b = 0; b < XCR_BYTES; b++) begin : g_shadow
    logic [7:0] shadowByte;
    always_ff @(posedge clk) begin
      if (!rstN)                    shadowByte <= 8'h00;
      else if (strobes.shadowWr[b]) shadowByte <= wrData;
    end
    assign shadowVec[8*b +: 8] = shadowByte;
  end

  assign stepVal = strobes.decTwo ? COUNT_W'(2) : COUNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)               liveCount <= '0;
    else if (strobes.clear)  liveCount <= '0;
    else if (strobes.reload) liveCount <= shadowVec;
    else if (strobes.dec)    liveCount <= (liveCount <= stepVal) ? '0 : liveCount - stepVal;
  end

  assign atOne   = (liveCount == COUNT_W'(1));
  assign atTwo   = (liveCount == COUNT_W'(2));
  assign effLen  = (liveCount == '0) ? ZERO_LEN : liveCount;
  assign xferLen = (pendSize < effLen) ? pendSize : effLen;

  always_comb begin
    rdData = 8'h00;
    if (int'(rdSel) == HI_SEL && !hiWritten) rdData = CHIP_ID;
    else if (int'(rdSel) < XCR_BYTES)       rdData = liveCount[8*rdSel +: 8];
  end
endmodule

// File: rtl/xfer_count_regs.sv
module xfer_count_regs
  import xcr_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'hA2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [7:0]  wrData,
  input  logic [1:0]  rdSel,
  output logic [7:0]  rdData,
  input  logic        decEn,
  input  logic        decTwo,
  input  logic        doneIn,
  input  logic [23:0] pendSize,
  output logic [23:0] liveCount,
  output logic [23:0] effLen,
  output logic [23:0] xferLen,
  output logic        tcFlag,
  output logic        dmaMode
);
  xcrStrobes_t strobes;
  logic atOne, atTwo, hiWritten;

  xcr_ctrl #(.SEL_W(2)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .decEn(decEn), .decTwo(decTwo), .doneIn(doneIn),
    .atOne(atOne), .atTwo(atTwo), .strobes(strobes),
    .tcFlag(tcFlag), .dmaMode(dmaMode), .hiWritten(hiWritten)
  );

  xcr_datapath #(.SEL_W(2), .CHIP_ID(CHIP_ID)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .rdSel(rdSel), .hiWritten(hiWritten), .pendSize(pendSize),
    .rdData(rdData), .liveCount(liveCount), .effLen(effLen),
    .xferLen(xferLen), .atOne(atOne), .atTwo(atTwo)
  );
endmodule

// File: rtl/xcr_checker.sv
module xcr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  wrSel,
  input logic [7:0]  wrData,
  input logic        decEn,
  input logic        doneIn,
  input logic [23:0] pendSize,
  input logic [23:0] liveCount,
  input logic [23:0] effLen,
  input logic [23:0] xferLen,
  input logic        tcFlag,
  input logic        dmaMode
);
  p_tc_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel != 2'd3 && !decEn && !doneIn) |=> !tcFlag);

  p_dma_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd3 && wrData[7]) |=> dmaMode);

  p_dma_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd3 && !wrData[7] && !decEn && !doneIn) |=> (!dmaMode && $stable(liveCount)));

  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    (liveCount == 24'd0) |-> (effLen == 24'h010000));

  p_min_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    (xferLen <= effLen) && (xferLen <= pendSize));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (decEn && !doneIn && !(wrEn && wrSel == 2'd3 && wrData[7]) && liveCount == 24'd0) |=> (liveCount == 24'd0));

  p_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneIn |=> (liveCount == 24'd0 && tcFlag));
endmodule

bind xfer_count_regs xcr_checker i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .decEn(decEn), .doneIn(doneIn), .pendSize(pendSize),
  .liveCount(liveCount), .effLen(effLen), .xferLen(xferLen),
  .tcFlag(tcFlag), .dmaMode(dmaMode)
);

// File: tb/test_xfer_count_regs.sv
`timescale 1ns/1ps
module test_xfer_count_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [7:0]  wrData = 8'h00;
  logic [1:0]  rdSel = 2'd0;
  logic [7:0]  rdData;
  logic        decEn = 1'b0;
  logic        decTwo = 1'b0;
  logic        doneIn = 1'b0;
  logic [23:0] pendSize = 24'hFFFFFF;
  logic [23:0] liveCount, effLen, xferLen;
  logic        tcFlag, dmaMode;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  xfer_count_regs i_xfer_count_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .decEn(decEn), .decTwo(decTwo),
    .doneIn(doneIn), .pendSize(pendSize), .liveCount(liveCount),
    .effLen(effLen), .xferLen(xferLen), .tcFlag(tcFlag), .dmaMode(dmaMode)
  );

  task automatic check(input logic [23:0] act, input logic [23:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge; return at the next falling edge.
  task automatic cyc(input logic we, input logic [1:0] sel, input logic [7:0] d,
                     input logic dec, input logic two, input logic done);
    wrEn = we; wrSel = sel; wrData = d; decEn = dec; decTwo = two; doneIn = done;
    @(negedge clk);
    wrEn = 1'b0; decEn = 1'b0; decTwo = 1'b0; doneIn = 1'b0;
  endtask

  task automatic loadCount(input logic [23:0] v);
    cyc(1'b1, 2'd0, v[7:0], 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd1, v[15:8], 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd2, v[23:16], 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd3, 8'h80, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testReset();
    check(liveCount, 24'd0, "R1 live count");
    check({23'd0, tcFlag}, 24'd0, "R1 tc");
    check({23'd0, dmaMode}, 24'd0, "R1 dma");
    rdSel = 2'd2; #1;
    check({16'd0, rdData}, 24'h0000A2, "R1 chip id");
    check(effLen, 24'h010000, "R7 zero means max");
  endtask

  task automatic testShadow();
    cyc(1'b1, 2'd0, 8'h34, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd1, 8'h12, 1'b0, 1'b0, 1'b0);
    check(liveCount, 24'd0, "R2 shadow only");
    rdSel = 2'd2; #1;
    check({16'd0, rdData}, 24'h0000A2, "R4 id before high write");
    cyc(1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0);
    rdSel = 2'd2; #1;
    check({16'd0, rdData}, 24'h000000, "R4 live high after write");
  endtask

  task automatic testReload();
    cyc(1'b1, 2'd3, 8'h80, 1'b0, 1'b0, 1'b0);
    check(liveCount, 24'h001234, "R5 reload");
    check({23'd0, dmaMode}, 24'd1, "R5 dma set");
    rdSel = 2'd0; #1;
    check({16'd0, rdData}, 24'h34, "R6 low byte");
    rdSel = 2'd1; #1;
    check({16'd0, rdData}, 24'h12, "R6 middle byte");
    check(effLen, 24'h001234, "R7 nonzero");
    cyc(1'b1, 2'd0, 8'h99, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd3, 8'h01, 1'b0, 1'b0, 1'b0);
    check({23'd0, dmaMode}, 24'd0, "R5 dma clear");
    check(liveCount, 24'h001234, "R5 no reload without flag");
    pendSize = 24'h000100; #1;
    check(xferLen, 24'h000100, "R8 pend smaller");
    pendSize = 24'h002000; #1;
    check(xferLen, 24'h001234, "R8 count smaller");
  endtask

  task automatic testDecrement();
    loadCount(24'h000003);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    check(liveCount, 24'd2, "R9 step one");
    check({23'd0, tcFlag}, 24'd0, "R9 no tc yet");
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0);
    check(liveCount, 24'd0, "R9 step two to zero");
    check({23'd0, tcFlag}, 24'd1, "R9 tc at zero");
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
    check(liveCount, 24'd0, "R9 no wrap");
    pendSize = 24'h020000; #1;
    check(xferLen, 24'h010000, "R8 zero count max");
    cyc(1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 1'b0);
    check({23'd0, tcFlag}, 24'd0, "R3 write clears tc");
    cyc(1'b1, 2'd3, 8'h80, 1'b0, 1'b0, 1'b0);
    check(liveCount, 24'd1, "R5 reload one");
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0);
    check(liveCount, 24'd0, "R9 saturate two from one");
    check({23'd0, tcFlag}, 24'd1, "R9 tc on saturate");
  endtask

  task automatic testDone();
    loadCount(24'h0ABCDE);
    check(liveCount, 24'h0ABCDE, "R6 full assemble");
    check({23'd0, tcFlag}, 24'd0, "R3 tc cleared by load");
    cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    check(liveCount, 24'd0, "R10 done zeroes");
    check({23'd0, tcFlag}, 24'd1, "R10 done sets tc");
  endtask

  task automatic testPriority();
    cyc(1'b1, 2'd0, 8'h05, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd1, 8'h00, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 2'd3, 8'h80, 1'b1, 1'b0, 1'b0);
    check(liveCount, 24'd5, "R11 reload beats decrement");
    cyc(1'b1, 2'd3, 8'h80, 1'b0, 1'b0, 1'b1);
    check(liveCount, 24'd0, "R11 done beats reload");
    check({23'd0, tcFlag}, 24'd1, "R11 done tc");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testShadow();
    testReload();
    testDecrement();
    testDone();
    testPriority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule